// File: doc/BRIEF.md
# Mode-Dependent Shared RAM Slot Arbiter

This block shares one RAM between a CPU and a video fetch engine. It counts master clock ticks in groups of eight, and each group forms one RAM access slot of 500 ns (one 2 MHz cycle at a 16 MHz master clock). For each slot it decides whether the video fetch or the CPU owns the RAM. The decision depends on the screen mode and on the beam position. A slot that falls inside the fetch window (an active display line, and a slot index below the fetch limit) can be taken by video. Every other slot goes to the CPU, so the CPU's effective rate falls below 2 MHz only while screen data is being fetched.

The block drives a CPU clock enable that pulses once for each slot the CPU can use. It also drives a video-fetch strobe, a slot-owner code, the slot-in-line, line and frame counters, and a count of CPU-usable slots in the last complete frame. That count lets a system check the CPU bandwidth for each mode. With the default parameters a line has 128 slots and a frame has 312 lines, which gives 39936 slots per frame.

Top module: `ram_arbiter`

## Requirements
- R1: While rst_ni is low, the block clears the tick, slot, line, frame and bandwidth counters to zero, and cpu_ce_o and vid_stb_o stay low. The mode register resets to mode 0 and the request register resets to 0.
- R2: A slot lasts exactly 8 ticks. owner_o holds one value for all 8 ticks of a slot.
- R3: In modes 0 to 3, every slot inside the fetch window is a video slot (owner code 2).
- R4: In modes 4 to 6, a slot inside the fetch window is a video slot when its slot index is even. When the index is odd, the slot is a CPU slot.
- R5: In mode 7, and in every slot outside the fetch window, the slot is not a video slot. cpu_ce_o pulses exactly once in each non-video slot, on the slot's last tick (tick 7). It never pulses in a video slot.
- R6: vid_stb_o is high for exactly one tick in each video slot, on tick VID_PHASE (4 by default). It is never high in other slots.
- R7: slot_o counts 0 to SLOTS_PER_LINE-1 and then wraps. line_o advances when slot_o wraps and counts 0 to LINES_PER_FRAME-1. frame_o increments when the last slot of the last line ends.
- R8: mode_i and cpu_req_i are sampled only on tick 7 of a slot, and they take effect from the next slot. A change on any other tick has no effect on the current slot.
- R9: A non-video slot has owner code 1 (CPU) if the sampled request was high, and owner code 0 (idle) if it was low.
- R10: When a frame ends, cpu_slots_o loads the number of non-video slots in that frame. It then holds that value until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16 MHz master clock (one tick per cycle) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Screen mode 0 to 7 |
| cpu_req_i | input | 1 | CPU wants the RAM in the next slot |
| cpu_ce_o | output | 1 | CPU clock enable, one tick per CPU-usable slot |
| vid_stb_o | output | 1 | Video fetch strobe |
| owner_o | output | 2 | Slot owner: 0 idle, 1 CPU, 2 video |
| slot_o | output | clog2(SLOTS_PER_LINE) | Slot index within the line |
| line_o | output | clog2(LINES_PER_FRAME) | Line index within the frame |
| frame_o | output | FRAME_W | Frame counter |
| cpu_slots_o | output | clog2(SLOTS_PER_LINE*LINES_PER_FRAME+1) | Non-video slots in the last complete frame |

## Verification
On every cycle, the inline assertions check the following. The owner code stays steady within a slot. The clock enable never coincides with a video slot, and the strobe never lasts two ticks. The slot and frame counters step correctly. The sampled mode and the bandwidth count hold between their update points. Only the bench's scenarios can show which slots each mode gives to video, that a mid-slot mode or request change is ignored, and that the per-frame CPU slot totals are right for each mode. The bench covers these across five frames with different modes and a request pattern that toggles.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;
  localparam int TICKS_PER_SLOT = 8;
  localparam int TICK_W = $clog2(TICKS_PER_SLOT);

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_VID  = 2'd2
  } owner_e;
endpackage

// File: rtl/ram_arb_tick.sv
module ram_arb_tick
  import ram_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [TICK_W-1:0] tick_o,
  output logic              slot_end_o
);
  logic [TICK_W-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + 1'b1;
  end

  assign tick_o     = tick_q;
  assign slot_end_o = (tick_q == TICK_W'(TICKS_PER_SLOT - 1));
endmodule

// File: rtl/ram_arb_beam.sv
module ram_arb_beam #(
  parameter int SLOTS_PER_LINE  = 128,
  parameter int LINES_PER_FRAME = 312,
  parameter int FRAME_W         = 8,
  localparam int SLOT_W = $clog2(SLOTS_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               slot_end_i,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_end_o
);
  logic [SLOT_W-1:0]  slot_q;
  logic [LINE_W-1:0]  line_q;
  logic [FRAME_W-1:0] frame_q;
  logic slot_last, line_last;

  assign slot_last = (slot_q == SLOT_W'(SLOTS_PER_LINE - 1));
  assign line_last = (line_q == LINE_W'(LINES_PER_FRAME - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      line_q  <= '0;
      frame_q <= '0;
    end else if (slot_end_i) begin
      if (slot_last) begin
        slot_q <= '0;
        if (line_last) begin
          line_q  <= '0;
          frame_q <= frame_q + 1'b1;
        end else begin
          line_q <= line_q + 1'b1;
        end
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign slot_o      = slot_q;
  assign line_o      = line_q;
  assign frame_o     = frame_q;
  assign frame_end_o = slot_end_i && slot_last && line_last;

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end_i && !slot_last) |=> (slot_o == $past(slot_o) + 1'b1)); // R7
  AST_FRAME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> (frame_o == $past(frame_o) + 1'b1) && (line_o == '0)); // R7
endmodule

// File: rtl/ram_arb_owner.sv
module ram_arb_owner
  import ram_arb_pkg::*;
#(
  parameter int SLOTS_PER_LINE  = 128,
  parameter int LINES_PER_FRAME = 312,
  parameter int ACTIVE_LINES    = 256,
  parameter int FETCH_SLOTS     = 80,
  localparam int SLOT_W = $clog2(SLOTS_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  input  logic [2:0]        mode_i,
  input  logic              req_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [LINE_W-1:0] line_i,
  output owner_e            owner_o
);
  logic [2:0] mode_q;
  logic       req_q;
  logic       line_act, slot_act, vid;

  // Mode and request latch only at the slot boundary.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 3'd0;
      req_q  <= 1'b0;
    end else if (slot_end_i) begin
      mode_q <= mode_i;
      req_q  <= req_i;
    end
  end

  generate
    if (ACTIVE_LINES >= LINES_PER_FRAME) begin : g_all_lines
      assign line_act = 1'b1;
    end else begin : g_some_lines
      assign line_act = (line_i < LINE_W'(ACTIVE_LINES));
    end
    if (FETCH_SLOTS >= SLOTS_PER_LINE) begin : g_all_slots
      assign slot_act = 1'b1;
    end else begin : g_some_slots
      assign slot_act = (slot_i < SLOT_W'(FETCH_SLOTS));
    end
  endgenerate

  always_comb begin
    vid = 1'b0;
    if (line_act && slot_act) begin
      if (!mode_q[2])                          vid = 1'b1;
      else if (mode_q != 3'd7 && !slot_i[0])   vid = 1'b1;
    end
    if (vid)        owner_o = OWN_VID;
    else if (req_q) owner_o = OWN_CPU;
    else            owner_o = OWN_IDLE;
  end

  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end_i |=> $stable(mode_q) && $stable(req_q)); // R8
endmodule

// File: rtl/ram_arb_bw.sv
module ram_arb_bw #(
  parameter int BW_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            slot_end_i,
  input  logic            frame_end_i,
  input  logic            cpu_slot_i,
  output logic [BW_W-1:0] count_o
);
  logic [BW_W-1:0] acc_q, count_q;
  logic            inc;

  assign inc = slot_end_i && cpu_slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      count_q <= '0;
    end else if (frame_end_i) begin
      count_q <= acc_q + BW_W'(inc);
      acc_q   <= '0;
    end else if (inc) begin
      acc_q <= acc_q + 1'b1;
    end
  end

  assign count_o = count_q;

  AST_BW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> $stable(count_o)); // R10
endmodule

// File: rtl/ram_arbiter.sv
module ram_arbiter
  import ram_arb_pkg::*;
#(
  parameter int SLOTS_PER_LINE  = 128,
  parameter int LINES_PER_FRAME = 312,
  parameter int ACTIVE_LINES    = 256,
  parameter int FETCH_SLOTS     = 80,
  parameter int VID_PHASE       = 4,
  parameter int FRAME_W         = 8,
  localparam int SLOT_W = $clog2(SLOTS_PER_LINE),
  localparam int LINE_W = $clog2(LINES_PER_FRAME),
  localparam int BW_W   = $clog2(SLOTS_PER_LINE * LINES_PER_FRAME + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic               cpu_req_i,
  output logic               cpu_ce_o,
  output logic               vid_stb_o,
  output logic [1:0]         owner_o,
  output logic [SLOT_W-1:0]  slot_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [BW_W-1:0]    cpu_slots_o
);
  logic [TICK_W-1:0] tick;
  logic              slot_end, frame_end, cpu_slot;
  owner_e            owner;

  ram_arb_tick u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick),
    .slot_end_o (slot_end)
  );

  ram_arb_beam #(
    .SLOTS_PER_LINE  (SLOTS_PER_LINE),
    .LINES_PER_FRAME (LINES_PER_FRAME),
    .FRAME_W         (FRAME_W)
  ) u_beam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_end_i  (slot_end),
    .slot_o      (slot_o),
    .line_o      (line_o),
    .frame_o     (frame_o),
    .frame_end_o (frame_end)
  );

  ram_arb_owner #(
    .SLOTS_PER_LINE  (SLOTS_PER_LINE),
    .LINES_PER_FRAME (LINES_PER_FRAME),
    .ACTIVE_LINES    (ACTIVE_LINES),
    .FETCH_SLOTS     (FETCH_SLOTS)
  ) u_owner (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slot_end_i (slot_end),
    .mode_i     (mode_i),
    .req_i      (cpu_req_i),
    .slot_i     (slot_o),
    .line_i     (line_o),
    .owner_o    (owner)
  );

  assign cpu_slot = (owner != OWN_VID);

  ram_arb_bw #(.BW_W(BW_W)) u_bw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_end_i  (slot_end),
    .frame_end_i (frame_end),
    .cpu_slot_i  (cpu_slot),
    .count_o     (cpu_slots_o)
  );

  assign owner_o   = owner;
  assign cpu_ce_o  = slot_end && cpu_slot;
  assign vid_stb_o = (tick == TICK_W'(VID_PHASE)) && (owner == OWN_VID);

  AST_OWNER_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_end |=> (owner_o == $past(owner_o))); // R2
  AST_CE_NEVER_VID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == 2'd2) |-> !cpu_ce_o); // R5
  AST_STB_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_stb_o |=> !vid_stb_o); // R6
endmodule

// File: tb/ram_arbiter_test.sv
module ram_arbiter_test;
  localparam int SL  = 16;
  localparam int LN  = 6;
  localparam int ACT = 4;
  localparam int FET = 10;
  localparam int PH  = 4;
  localparam int F   = SL * LN;
  localparam int N   = 5 * F;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       cpu_req_i = 1'b0;
  logic       cpu_ce_o, vid_stb_o;
  logic [1:0] owner_o;
  logic [3:0] slot_o;
  logic [2:0] line_o;
  logic [7:0] frame_o;
  logic [6:0] cpu_slots_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    int own;
    int sl;
    int ln;
    int fr;
  } exp_t;
  exp_t q[$];

  ram_arbiter #(
    .SLOTS_PER_LINE(SL), .LINES_PER_FRAME(LN), .ACTIVE_LINES(ACT),
    .FETCH_SLOTS(FET), .VID_PHASE(PH), .FRAME_W(8)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .cpu_req_i(cpu_req_i),
    .cpu_ce_o(cpu_ce_o), .vid_stb_o(vid_stb_o), .owner_o(owner_o),
    .slot_o(slot_o), .line_o(line_o), .frame_o(frame_o),
    .cpu_slots_o(cpu_slots_o)
  );

  always #5 clk = ~clk;

  function automatic int plan_mode(int s);
    case (s / F)
      0: return 0;
      1: return 5;
      2: return 7;
      3: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic bit plan_req(int s);
    return (s % 3) != 0;
  endfunction

  // R3 R4 R5 R9: 0 idle, 1 cpu, 2 video
  function automatic int exp_owner(int md, bit rq, int sl, int ln);
    if (ln < ACT && sl < FET) begin
      if (md <= 3) return 2;
      if (md <= 6 && (sl % 2) == 0) return 2;
    end
    return rq ? 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driver();
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < 8; t++) begin
        if (t == 0) begin
          exp_t e;
          e.sl  = (s % F) % SL;
          e.ln  = (s % F) / SL;
          e.fr  = s / F;
          e.own = exp_owner(plan_mode(s), plan_req(s), e.sl, e.ln);
          q.push_back(e);
          // R8: off-boundary values that must be ignored
          mode_i    = 3'(plan_mode(s + 1)) ^ 3'd4;
          cpu_req_i = ~plan_req(s + 1);
        end
        if (t == 3) begin
          mode_i    = 3'(plan_mode(s + 1));
          cpu_req_i = plan_req(s + 1);
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic monitor();
    int bw_exp = 0;
    for (int s = 0; s < N; s++) begin
      int own0 = 0, sl0 = 0, ln0 = 0, fr0 = 0, stb_n = 0, ce_n = 0;
      bit steady = 1, stb_ph = 1, ce_ph = 1;
      for (int t = 0; t < 8; t++) begin
        if (t == 0) begin
          if (s > 0 && (s % F) == 0) begin
            check(int'(cpu_slots_o) == bw_exp, "R10 frame cpu slots", int'(cpu_slots_o), bw_exp);
            bw_exp = 0;
          end
          own0 = int'(owner_o); sl0 = int'(slot_o); ln0 = int'(line_o); fr0 = int'(frame_o);
        end else if (int'(owner_o) != own0) steady = 0;
        if (vid_stb_o) begin stb_n++; if (t != PH) stb_ph = 0; end
        if (cpu_ce_o)  begin ce_n++;  if (t != 7)  ce_ph = 0; end
        if (t == 7) begin
          exp_t e = q.pop_front();
          check(own0 == e.own, "R3/R4/R5/R8/R9 owner", own0, e.own);
          check(steady, "R2 owner steady in slot", 0, 1);
          check(sl0 == e.sl && ln0 == e.ln && fr0 == (e.fr % 256), "R7 position",
                sl0 + 100 * ln0, e.sl + 100 * e.ln);
          check(stb_n == (e.own == 2 ? 1 : 0) && stb_ph, "R6 strobe count", stb_n, e.own == 2 ? 1 : 0);
          check(ce_n == (e.own == 2 ? 0 : 1) && ce_ph, "R5 cpu enable count", ce_n, e.own == 2 ? 0 : 1);
          if (e.own != 2) bw_exp++;
        end
        @(negedge clk);
      end
    end
    check(int'(cpu_slots_o) == bw_exp, "R10 last frame cpu slots", int'(cpu_slots_o), bw_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(slot_o == 0 && line_o == 0 && frame_o == 0, "R1 counters in reset", int'(slot_o), 0);
    check(cpu_slots_o == 0, "R1 bandwidth in reset", int'(cpu_slots_o), 0);
    check(!cpu_ce_o && !vid_stb_o, "R1 strobes low in reset", int'(cpu_ce_o) + int'(vid_stb_o), 0);
    check(int'(owner_o) == 2, "R1 mode 0 video at slot 0 in reset", int'(owner_o), 2);
    rst_ni = 1'b1;
    fork
      driver();
      monitor();
    join
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule